// File: doc/BRIEF.md
# Three-Level Nested Interrupt Controller

This block gathers twelve interrupt sources and presents them to a CPU core as one request line with a vector address. Four sources are external pins, and each pin passes through its own trigger detector. The other eight are single-cycle event pulses from on-chip timers, the serial unit, the display engine and a port-change detector. Pairs of sources share a vector in three places, so the twelve sources fold onto nine vectors. Each vector has one priority bit. For the two dedicated pin vectors that bit chooses between the high and the highest tier. For the other seven it chooses between low and high.

The controller keeps a record of which tiers are in service, as an eight-state machine whose state is the set of active tiers. A request is raised only when its tier is strictly above the tier now in service. The acknowledge strobe adds the granted tier to the set. The return strobe removes the topmost tier and so drops back to the tier that was interrupted. When an acknowledge is accepted, edge-type pending flags of the granted vector are cleared. A level-type pin keeps requesting for as long as the pin holds its active level.

States: SVC_NONE, SVC_L, SVC_H, SVC_LH, SVC_T, SVC_LT, SVC_HT, SVC_LHT. Each letter names a tier in service: L low, H high, T highest. There are three transitions. PUSH on an accepted acknowledge sets the granted tier. POP on return clears the highest set tier. POP+PUSH happens when both strobes come in the same cycle: the pop is applied first, then the push.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset `irq` is 0, `svc_level` is 0 and `vec_addr` is 0; `vec_addr` is 0 whenever `irq` is 0.
- R2: Vector v has address 0x03 + 8*v. Sources map to vectors as follows: pin 0 → 0, pin 1 → 1, pin 2 and event 0 → 2, pin 3 → 3, event 1 → 4, events 2 and 3 → 5, event 4 → 6, events 5 and 6 → 7, event 7 → 8.
- R3: Pins 0 and 1 take a 2-bit mode from `pin_mode[2p+1:2p]`: 00 rising edge, 01 falling edge, 10 high level, 11 low level.
- R4: Pins 2 and 3 take a 2-bit mode: 00 rising edge, 01 falling edge, 1x both edges; they have no level mode.
- R5: A high pulse of one cycle on pin 0 or 1 is accepted. A pulse on pin 2 or 3 is accepted only if it is held for at least two cycles; a one-cycle pulse is ignored.
- R6: `svc_level` encodes tiers as 0 none, 1 low, 2 high, 3 highest. Vectors 0 and 1 take tier 2 when `vec_pri[v]` is 0 and tier 3 when it is 1. Vectors 2 to 8 take tier 1 when it is 0 and tier 2 when it is 1.
- R7: Among active requests the highest tier wins. Within one tier the lower vector number wins.
- R8: `irq` is 1 only when the winning tier is strictly above `svc_level`. An acknowledge accepted while `irq` is 1 raises `svc_level` to the granted tier.
- R9: `ret` lowers `svc_level` to the tier that was active before the latest push. `ret` while `svc_level` is 0 has no effect.
- R10: An acknowledge clears the edge pending flags of every enabled source of the granted vector. A level-mode pin keeps requesting after the acknowledge while it holds its active level.
- R11: A source whose bit in `src_en` is 0 never requests, but its pending flag is kept and raises a request once the source is enabled.
- R12: An event arriving in the same cycle as the acknowledge that clears its flag leaves the flag pending.
- R13: `ack` while `irq` is 0 has no effect.
- R14: `ack` and `ret` in the same cycle pop the top tier, then push the granted tier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 4 | Raw external interrupt pins 0..3 |
| evt_pulse | input | 8 | Internal single-cycle event pulses 0..7 |
| src_en | input | 12 | Enable per source, source index order of R2 |
| vec_pri | input | 9 | Priority bit per vector |
| pin_mode | input | 8 | Trigger mode, two bits per pin |
| ack | input | 1 | Acknowledge strobe from the CPU |
| ret | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Interrupt request to the CPU |
| vec_addr | output | 8 | Address of the winning vector |
| svc_level | output | 2 | Tier currently in service |

## Verification
Two pairs of functions can fall in the same cycle. In the first, an acknowledge clears a flag while a new event sets that same flag. The bench provokes this by raising the vector's event pulse on the cycle the acknowledge is taken. It judges the result by showing that, after a return, the request comes back with the same address. In the second, a return and an acknowledge are both strobed while a higher-tier request is waiting; the expected service tier after one later return is 0, not the tier that was interrupted. An arbitration sweep covers all vector pairs and priority bits, and its expected winner and tier are computed arithmetically.

// File: rtl/nic_pkg.sv
package nic_pkg;
    localparam int NUM_SRC  = 12;
    localparam int NUM_VEC  = 9;
    localparam int NUM_PIN  = 4;
    localparam int NUM_EVT  = 8;
    localparam int LVL_PINS = 2;
    localparam int VEC_W    = $clog2(NUM_VEC);

    typedef logic [1:0] tier_t;

    typedef enum logic [2:0] {
        SVC_NONE = 3'b000,
        SVC_L    = 3'b001,
        SVC_H    = 3'b010,
        SVC_LH   = 3'b011,
        SVC_T    = 3'b100,
        SVC_LT   = 3'b101,
        SVC_HT   = 3'b110,
        SVC_LHT  = 3'b111
    } svc_t;

    // shared vectors sit after sources 2, 6 and 9
    function automatic int src_vec(input int s);
        return s - int'(s >= 3) - int'(s >= 7) - int'(s >= 10);
    endfunction

    function automatic int pin_src(input int p);
        return (p < 3) ? p : 4;
    endfunction

    function automatic int evt_src(input int e);
        return (e == 0) ? 3 : ((e == 1) ? 5 : e + 4);
    endfunction

    function automatic tier_t vec_tier(input int v, input logic pri);
        if (v < LVL_PINS) return pri ? 2'd3 : 2'd2;
        return pri ? 2'd2 : 2'd1;
    endfunction
endpackage

// File: rtl/nic_pin_detect.sv
module nic_pin_detect #(
    parameter bit FILTERED = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic [1:0] mode,
    output logic       edge_hit,
    output logic       level_hit
);
    logic cur, prv;

    generate
        if (FILTERED) begin : g_filt
            logic s_a, s_b;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    s_a <= 1'b0;
                    s_b <= 1'b0;
                    cur <= 1'b0;
                    prv <= 1'b0;
                end else begin
                    s_a <= pin;
                    s_b <= s_a;
                    if (s_a == s_b) cur <= s_a;
                    prv <= cur;
                end
            end
            always_comb begin
                edge_hit = (cur & ~prv & (mode == 2'b00 || mode[1]))
                         | (~cur & prv & (mode == 2'b01 || mode[1]));
                level_hit = 1'b0;
            end
        end else begin : g_raw
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cur <= 1'b0;
                    prv <= 1'b0;
                end else begin
                    cur <= pin;
                    prv <= cur;
                end
            end
            always_comb begin
                edge_hit  = (mode == 2'b00) ? (cur & ~prv)
                          : (mode == 2'b01) ? (~cur & prv) : 1'b0;
                level_hit = (mode == 2'b10) ? cur
                          : (mode == 2'b11) ? ~cur : 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/nic_pending.sv
module nic_pending #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= '0;
        else        flag <= (flag & ~clr) | set;
    end
endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
    import nic_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic [NUM_VEC-1:0] vec_pri,
    output logic               any,
    output logic [VEC_W-1:0]   win_vec,
    output tier_t              win_tier
);
    logic [NUM_VEC-1:0] vreq;

    always_comb begin
        vreq = '0;
        for (int s = 0; s < NUM_SRC; s++)
            vreq[src_vec(s)] = vreq[src_vec(s)] | req[s];
    end

    // descending scan: a tie keeps the later (lower) vector
    always_comb begin
        any      = 1'b0;
        win_vec  = '0;
        win_tier = 2'd0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (vreq[v] && vec_tier(v, vec_pri[v]) >= win_tier) begin
                any      = 1'b1;
                win_vec  = VEC_W'(v);
                win_tier = vec_tier(v, vec_pri[v]);
            end
        end
    end
endmodule

// File: rtl/nic_svc_fsm.sv
module nic_svc_fsm
    import nic_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  push,
    input  tier_t push_tier,
    input  logic  pop,
    output tier_t level
);
    svc_t state, state_nx;

    always_comb begin
        logic [2:0] m;
        m = state;
        if (pop) begin
            if (m[2])      m[2] = 1'b0;
            else if (m[1]) m[1] = 1'b0;
            else           m[0] = 1'b0;
        end
        if (push) begin
            case (push_tier)
                2'd1:    m[0] = 1'b1;
                2'd2:    m[1] = 1'b1;
                2'd3:    m[2] = 1'b1;
                default: ;
            endcase
        end
        state_nx = svc_t'(m);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SVC_NONE;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            SVC_NONE:        level = 2'd0;
            SVC_L:           level = 2'd1;
            SVC_H, SVC_LH:   level = 2'd2;
            SVC_T, SVC_LT,
            SVC_HT, SVC_LHT: level = 2'd3;
        endcase
    end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PIN-1:0]   ext_pin,
    input  logic [NUM_EVT-1:0]   evt_pulse,
    input  logic [NUM_SRC-1:0]   src_en,
    input  logic [NUM_VEC-1:0]   vec_pri,
    input  logic [2*NUM_PIN-1:0] pin_mode,
    input  logic                 ack,
    input  logic                 ret,
    output logic                 irq,
    output logic [ADDR_W-1:0]    vec_addr,
    output logic [1:0]           svc_level
);
    logic [NUM_PIN-1:0] pin_edge, pin_lvl;
    logic [NUM_SRC-1:0] set_v, clr_v, pend, lvl_mode, lvl_val, req;
    logic               any, take;
    logic [VEC_W-1:0]   win_vec;
    tier_t              win_tier, cur_tier;

    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
        nic_pin_detect #(.FILTERED(p >= LVL_PINS)) u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin       (ext_pin[p]),
            .mode      (pin_mode[2*p +: 2]),
            .edge_hit  (pin_edge[p]),
            .level_hit (pin_lvl[p])
        );
    end

    always_comb begin
        set_v    = '0;
        lvl_mode = '0;
        lvl_val  = '0;
        for (int p = 0; p < NUM_PIN; p++) begin
            set_v[pin_src(p)] = pin_edge[p];
            if (p < LVL_PINS) begin
                lvl_mode[pin_src(p)] = pin_mode[2*p+1];
                lvl_val[pin_src(p)]  = pin_lvl[p];
            end
        end
        for (int e = 0; e < NUM_EVT; e++)
            set_v[evt_src(e)] = evt_pulse[e];
    end

    assign req = src_en & ((lvl_mode & lvl_val) | (~lvl_mode & pend));

    nic_arbiter u_arb (
        .req      (req),
        .vec_pri  (vec_pri),
        .any      (any),
        .win_vec  (win_vec),
        .win_tier (win_tier)
    );

    assign irq  = any && (win_tier > cur_tier);
    assign take = ack && irq;

    always_comb begin
        for (int s = 0; s < NUM_SRC; s++)
            clr_v[s] = take && src_en[s] && (src_vec(s) == int'(win_vec));
    end

    nic_pending #(.N(NUM_SRC)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (set_v),
        .clr   (clr_v),
        .flag  (pend)
    );

    nic_svc_fsm u_svc (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (take),
        .push_tier (win_tier),
        .pop       (ret),
        .level     (cur_tier)
    );

    assign vec_addr  = irq ? ADDR_W'(VEC_BASE + VEC_STEP * int'(win_vec)) : '0;
    assign svc_level = cur_tier;
endmodule

// File: rtl/nic_checker.sv
module nic_checker #(
    parameter int ADDR_W   = 8,
    parameter int VEC_BASE = 3,
    parameter int VEC_STEP = 8,
    parameter int NUM_VEC  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack,
    input logic              ret,
    input logic              irq,
    input logic [ADDR_W-1:0] vec_addr,
    input logic [1:0]        svc_level
);
    localparam int LAST = VEC_BASE + VEC_STEP * (NUM_VEC - 1);

    a_r2_addr_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (int'(vec_addr) >= VEC_BASE && int'(vec_addr) <= LAST
                 && ((int'(vec_addr) - VEC_BASE) % VEC_STEP) == 0));

    a_r6_top_tier_pins_only: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && int'(vec_addr) > VEC_BASE + VEC_STEP) |=> svc_level != 2'd3);

    a_r8_push_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq && !ret) |=> svc_level > $past(svc_level));

    a_r9_pop_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !ack && svc_level != 2'd0) |=> svc_level < $past(svc_level));

    a_r9_no_drop_without_ret: assert property (@(posedge clk) disable iff (!rst_n)
        !ret |=> svc_level >= $past(svc_level));

    a_r13_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !irq && !ret) |=> $stable(svc_level));
endmodule

bind nest_irq_ctrl nic_checker #(
    .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .NUM_VEC(nic_pkg::NUM_VEC)
) i_nic_checker (
    .clk(clk), .rst_n(rst_n), .ack(ack), .ret(ret),
    .irq(irq), .vec_addr(vec_addr), .svc_level(svc_level)
);

// File: tb/test_nest_irq_ctrl.sv
`timescale 1ns/1ps
module test_nest_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ext_pin = '0;
    logic [7:0]  evt_pulse = '0;
    logic [11:0] src_en = '0;
    logic [8:0]  vec_pri = '0;
    logic [7:0]  pin_mode = '0;
    logic        ack = 1'b0;
    logic        ret = 1'b0;
    logic        irq;
    logic [7:0]  vec_addr;
    logic [1:0]  svc_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nest_irq_ctrl i_nest_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .evt_pulse(evt_pulse),
        .src_en(src_en), .vec_pri(vec_pri), .pin_mode(pin_mode),
        .ack(ack), .ret(ret), .irq(irq), .vec_addr(vec_addr), .svc_level(svc_level)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int tier(input int v, input int p);
        return (v < 2) ? 2 + p : 1 + p;
    endfunction

    function automatic int addr(input int v);
        return 3 + 8 * v;
    endfunction

    task automatic do_reset();
        ext_pin = '0; evt_pulse = '0; ack = 0; ret = 0;
        rst_n = 0;
        repeat (2) step();
        rst_n = 1;
        step();
    endtask

    task automatic pin_pulse(input int p, input int w);
        ext_pin[p] = 1'b1;
        repeat (w) step();
        ext_pin[p] = 1'b0;
        repeat (6) step();
    endtask

    task automatic evt(input int e);
        evt_pulse[e] = 1'b1;
        step();
        evt_pulse[e] = 1'b0;
        step();
    endtask

    task automatic fire(input int v);
        case (v)
            0: pin_pulse(0, 3);
            1: pin_pulse(1, 3);
            2: evt(0);
            3: pin_pulse(3, 3);
            4: evt(1);
            5: evt(2);
            6: evt(4);
            7: evt(5);
            default: evt(7);
        endcase
    endtask

    task automatic do_ack();
        ack = 1; step(); ack = 0;
    endtask

    task automatic do_ret();
        ret = 1; step(); ret = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 irq", irq, 0);
        chk("R1 svc_level", svc_level, 0);
        chk("R1 vec_addr", vec_addr, 0);

        // R2 R6 R7 R8 sweep over vector pairs and priority bits
        src_en = 12'hFFF;
        pin_mode = 8'h00;
        for (int a = 0; a < 9; a++) begin
            for (int b = 0; b < 9; b++) begin
                for (int pa = 0; pa < 2; pa++) begin
                    for (int pb = 0; pb < 2; pb++) begin
                        int la, lb, w, l;
                        if (a == b && pa != pb) continue;
                        vec_pri = '0;
                        vec_pri[a] = pa[0];
                        vec_pri[b] = pb[0];
                        fire(a);
                        fire(b);
                        la = tier(a, pa);
                        lb = tier(b, pb);
                        w = (la > lb || (la == lb && a <= b)) ? a : b;
                        l = (w == a) ? la : lb;
                        chk("R7 irq", irq, 1);
                        chk("R2 R7 winner addr", vec_addr, addr(w));
                        do_ack();
                        chk("R6 R8 granted tier", svc_level, l);
                        chk("R8 no equal-or-lower preempt", irq, 0);
                        do_ret();
                        chk("R9 back to none", svc_level, 0);
                        if (a != b) begin
                            chk("R10 loser still pending", vec_addr, addr(w == a ? b : a));
                            do_ack();
                            do_ret();
                        end
                        chk("R10 all cleared", irq, 0);
                    end
                end
            end
        end

        // R3 pin 0 falling edge
        do_reset();
        vec_pri = '0; src_en = 12'h001; pin_mode = 8'b0000_0001;
        ext_pin[0] = 1; repeat (4) step();
        chk("R3 rising ignored in falling mode", irq, 0);
        ext_pin[0] = 0; repeat (4) step();
        chk("R3 falling edge taken", vec_addr, 8'h03);
        do_ack(); do_ret();
        chk("R3 falling cleared", irq, 0);

        // R3 R10 pin 1 high level, then low level
        src_en = 12'h002; pin_mode = 8'b0000_1000;
        ext_pin[1] = 1; repeat (3) step();
        chk("R3 high level", vec_addr, 8'h0B);
        do_ack();
        chk("R6 pin vector tier high", svc_level, 2);
        do_ret();
        chk("R10 level persists after ack", irq, 1);
        ext_pin[1] = 0; repeat (2) step();
        chk("R3 level released", irq, 0);
        pin_mode = 8'b0000_1100; step();
        chk("R3 low level", vec_addr, 8'h0B);
        ext_pin[1] = 1; repeat (3) step();
        chk("R3 low level released", irq, 0);

        // R4 pin 3 both edges
        do_reset();
        src_en = 12'h010; pin_mode = 8'b1000_0000;
        ext_pin[3] = 1; repeat (6) step();
        chk("R4 both: rise", vec_addr, 8'h1B);
        do_ack(); do_ret();
        chk("R4 both: cleared", irq, 0);
        ext_pin[3] = 0; repeat (6) step();
        chk("R4 both: fall", vec_addr, 8'h1B);
        do_ack(); do_ret();

        // R4 pin 2 falling
        src_en = 12'h004; pin_mode = 8'b0001_0000;
        ext_pin[2] = 1; repeat (6) step();
        chk("R4 falling: rise ignored", irq, 0);
        ext_pin[2] = 0; repeat (6) step();
        chk("R4 falling taken", vec_addr, 8'h13);
        do_ack(); do_ret();

        // R5 pulse width
        do_reset();
        src_en = 12'h005; pin_mode = 8'h00;
        pin_pulse(2, 1);
        chk("R5 one-cycle pulse on pin 2 ignored", irq, 0);
        pin_pulse(2, 2);
        chk("R5 two-cycle pulse on pin 2 taken", vec_addr, 8'h13);
        do_ack(); do_ret();
        pin_pulse(0, 1);
        chk("R5 one-cycle pulse on pin 0 taken", vec_addr, 8'h03);
        do_ack(); do_ret();

        // R10 shared vector: both sources cleared
        src_en = 12'h00C;
        pin_pulse(2, 3); evt(0);
        chk("R2 shared vector addr", vec_addr, 8'h13);
        do_ack(); do_ret();
        chk("R10 shared sources cleared", irq, 0);

        // R11 disabled source keeps pending
        do_reset();
        src_en = 12'h000; vec_pri = '0;
        evt(1);
        chk("R11 disabled no request", irq, 0);
        src_en[5] = 1; step();
        chk("R11 pending kept", vec_addr, 8'h23);
        do_ack(); do_ret();

        // R13 ack when idle, R9 ret at level 0
        do_ack();
        chk("R13 idle ack ignored", svc_level, 0);
        do_ret();
        chk("R9 ret at level 0 ignored", svc_level, 0);
        chk("R9 ret at level 0 irq", irq, 0);

        // R8 R9 three-deep nesting
        do_reset();
        src_en = 12'hFFF; pin_mode = 8'h00; vec_pri = '0;
        vec_pri[5] = 1; vec_pri[0] = 1;
        fire(4); do_ack();
        chk("R8 nest low", svc_level, 1);
        fire(5);
        chk("R8 high preempts low", vec_addr, 8'h2B);
        do_ack();
        chk("R8 nest high", svc_level, 2);
        fire(4);
        chk("R8 low blocked under high", irq, 0);
        fire(0);
        chk("R8 highest preempts", vec_addr, 8'h03);
        do_ack();
        chk("R8 nest highest", svc_level, 3);
        do_ret();
        chk("R9 pop to high", svc_level, 2);
        do_ret();
        chk("R9 pop to low", svc_level, 1);
        chk("R8 same tier blocked", irq, 0);
        do_ret();
        chk("R9 pop to none", svc_level, 0);
        chk("R8 waiting low now raised", vec_addr, 8'h23);
        do_ack(); do_ret();

        // R12 event and clearing ack together
        do_reset();
        src_en = 12'hFFF; vec_pri = '0;
        fire(4);
        ack = 1; evt_pulse[1] = 1;
        step();
        ack = 0; evt_pulse[1] = 0;
        chk("R12 granted", svc_level, 1);
        do_ret();
        chk("R12 new event kept", vec_addr, 8'h23);
        do_ack(); do_ret();
        chk("R12 then cleared", irq, 0);

        // R14 ack and ret together
        vec_pri = '0; vec_pri[3] = 1;
        fire(4); do_ack();
        chk("R14 low in service", svc_level, 1);
        fire(3);
        chk("R14 high waiting", vec_addr, 8'h1B);
        ack = 1; ret = 1;
        step();
        ack = 0; ret = 0;
        chk("R14 pop then push", svc_level, 2);
        do_ret();
        chk("R14 low was popped", svc_level, 0);

        done = 1;
        finish_run();
    end
endmodule